// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is a two-wire bus slave in front of a small byte-wide memory of 128 locations kept in flip-flops. The bus clock and data lines are brought into the system clock domain through a synchroniser. The block pulls the data line low only through an open-drain enable output. It detects START, repeated START and STOP conditions, answers only to its own select byte, and serves current-address, random and sequential reads. It also takes single-byte writes and buffered block writes.

Written bytes first go into a write buffer. A STOP that follows at least one data byte moves them into the array through a programming cycle of fixed length. While that cycle runs the slave ignores its own select byte, so a master can poll until the slave answers again. A mode input picks the block size of a buffered write. A build parameter turns that input into a write-inhibit control instead.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is low, every memory byte is 0 and the address counter is 0.
- R2: The select byte arrives MSB first. It is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `chip_sel`. Bit 0 chooses read (1) or write (0).
- R3: A STOP that ends a write carrying at least one data byte starts a programming cycle of `PROG_CYCLES` system clocks. During that cycle the select byte is not acknowledged. Afterwards it is acknowledged again.
- R4: A random read is a write select, one address byte whose bit 7 is ignored, a repeated START and a read select. The first byte returned is the one stored at that address.
- R5: In a read, every byte the master acknowledges is followed by the byte at the next address. The address wraps from 127 to 0.
- R6: A current-address read returns the byte at the counter. After a read the counter is one past the last byte sent.
- R7: Page write applies when `WC_VARIANT`=0 with `mode_i` low, or when `WC_VARIANT`=1 with `mode_i` low. Successive data bytes go to successive addresses, and the low 3 address bits wrap inside the aligned 8-byte block. A later byte to the same location overwrites an earlier one.
- R8: Multibyte write applies when `WC_VARIANT`=0 with `mode_i` high. The low 2 address bits wrap inside the aligned 4-byte block.
- R9: When `WC_VARIANT`=1 with `mode_i` high, data bytes are not acknowledged, memory is unchanged and no programming cycle starts.
- R10: A write that carries only the address byte and then a STOP starts no programming cycle. The next select is acknowledged at once.
- R11: After the master leaves a read byte unacknowledged, the slave releases SDA and drives nothing until a START or STOP.
- R12: An acknowledge is driven during the 9th clock of an accepted byte. It is released at the falling edge that ends that clock, so it never corrupts the master's next bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pad, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| chip_sel | input | 3 | Slave address bits compared with select bits 3..1 |
| mode_i | input | 1 | Block-size select, or write inhibit when `WC_VARIANT`=1 |

## Verification
The bench builds two slaves on one shared bus. One has `WC_VARIANT`=0 and chip select 101. The other has `WC_VARIANT`=1 and chip select 010. This allows all eight chip-select values to be swept against both address matchers at once, and lets both block-write sizes and the write inhibit be tried side by side. `PROG_CYCLES` is set to 400. That is shorter than a full transaction, but a select sent right after a STOP still lands inside the cycle. The bench therefore sees both the busy refusal and the later recovery. With the full 128-byte array, one sequential read covers every location and the 127-to-0 wrap against an arithmetic model.

// File: rtl/i2c_ee_pkg.sv
// Shared types of the serial EEPROM slave: the protocol state and the
// kind of byte being received. Assumes nothing beyond 1800-2017.
package i2c_ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction addressed to us
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // 9th clock of a received byte
        ST_READ,   // shifting a data byte out
        ST_MACK,   // 9th clock of a sent byte, master answers
        ST_RNEXT,  // master acknowledged, next byte starts at next fall
        ST_WAIT    // ignore the bus until START or STOP
    } ee_state_t;

    typedef enum logic [1:0] {
        RX_DEV,    // select byte
        RX_ADDR,   // word address byte
        RX_DATA    // write data byte
    } rx_kind_t;

endpackage

// File: rtl/i2c_ee_sync.sv
// Brings the asynchronous bus lines into the clock domain and flags
// clock edges and START/STOP conditions, each as a one-cycle pulse.
// Assumes the bus is idle (both lines high) while reset is applied.
module i2c_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    // synchroniser chains plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_o     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_o;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/i2c_ee_prog_timer.sv
// Self-timed programming cycle: a start pulse loads a down-counter of
// CYCLES system clocks; busy is high while it runs, done marks its end.
// Assumes start is ignored while a cycle is already running.
module i2c_ee_prog_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q;

    // load on start when idle, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (start_i && cnt_q == '0)    cnt_q <= W'(CYCLES);
        else if (cnt_q != '0)               cnt_q <= cnt_q - W'(1);
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == W'(1));

    // R3
    prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/i2c_ee_store.sv
// Byte array of the slave with an asynchronous read port and a commit
// port that copies the marked slots of a write block in one cycle.
// Assumes BLK is a power of two dividing DEPTH.
module i2c_ee_store #(
    parameter int DEPTH = 128,
    parameter int BLK   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    input  logic              commit_i,
    input  logic [AW-BW-1:0]  commit_base,
    input  logic [BLK*8-1:0]  commit_data,
    input  logic [BLK-1:0]    commit_mask
);
    logic [7:0] mem_q [DEPTH];

    // clear on reset, write the marked block slots on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (commit_i) begin
            for (int i = 0; i < BLK; i++)
                if (commit_mask[i])
                    mem_q[{commit_base, BW'(i)}] <= commit_data[i*8 +: 8];
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
// Two-wire bus slave in front of a MEM_BYTES x 8 array. Decodes the select
// byte, word address, buffered writes and auto-incrementing reads; data is
// committed by a timed programming cycle after STOP. Assumes the system
// clock is at least several times faster than the bus clock and that the
// bus master does not stretch or glitch the clock.
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int MEM_BYTES   = 128,
    parameter int PAGE_BYTES  = 8,
    parameter int MULTI_BYTES = 4,
    parameter int PROG_CYCLES = 5000,
    parameter int WC_VARIANT  = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] chip_sel,
    input  logic       mode_i
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int MW = $clog2(MULTI_BYTES);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic prog_start, prog_busy, prog_done;

    ee_state_t state_q, nxt_q;
    rx_kind_t  kind_q, nxt_kind_q;
    logic [2:0]    bit_q;
    logic [7:0]    shreg_q;
    logic [AW-1:0] addr_q, addr_wr_next;
    logic          ack_phase_q, sda_oe_q, blk4_q, ack_ok;
    logic [PAGE_BYTES-1:0][7:0] wbuf_q;
    logic [PAGE_BYTES-1:0]      wmask_q;
    logic [AW-PW-1:0]           wbase_q;
    logic [7:0]                 rd_data;

    i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(prog_start),
        .busy_o(prog_busy), .done_o(prog_done)
    );

    i2c_ee_store #(.DEPTH(MEM_BYTES), .BLK(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr_q), .rd_data(rd_data),
        .commit_i(prog_done), .commit_base(wbase_q),
        .commit_data(wbuf_q), .commit_mask(wmask_q)
    );

    // acknowledge decision for the byte just shifted in
    always_comb begin
        unique case (kind_q)
            RX_DEV:  ack_ok = (shreg_q[7:4] == 4'b1010) &&
                              (shreg_q[3:1] == chip_sel) && !prog_busy;
            RX_ADDR: ack_ok = 1'b1;
            default: ack_ok = !((WC_VARIANT != 0) && mode_i);
        endcase
    end

    // next write address, wrapping inside the 4- or 8-byte block
    always_comb begin
        if (blk4_q) addr_wr_next = {addr_q[AW-1:MW], addr_q[MW-1:0] + MW'(1)};
        else        addr_wr_next = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
    end

    // bus protocol engine: conditions first, then the per-state bit work
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            nxt_q       <= ST_IDLE;
            kind_q      <= RX_DEV;
            nxt_kind_q  <= RX_DEV;
            bit_q       <= '0;
            shreg_q     <= '0;
            addr_q      <= '0;
            ack_phase_q <= 1'b0;
            sda_oe_q    <= 1'b0;
            blk4_q      <= 1'b0;
            wbuf_q      <= '0;
            wmask_q     <= '0;
            wbase_q     <= '0;
            prog_start  <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            if (prog_done) wmask_q <= '0;
            if (stop_det) begin
                state_q  <= ST_IDLE;
                sda_oe_q <= 1'b0;
                if (|wmask_q && !prog_busy) prog_start <= 1'b1;
            end else if (start_det) begin
                state_q     <= ST_RX;
                kind_q      <= RX_DEV;
                bit_q       <= '0;
                ack_phase_q <= 1'b0;
                sda_oe_q    <= 1'b0;
                if (!prog_busy) wmask_q <= '0;
            end else begin
                unique case (state_q)
                    ST_RX: if (scl_rise) begin
                        shreg_q <= {shreg_q[6:0], sda_s};
                        bit_q   <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            state_q     <= ST_ACK;
                            ack_phase_q <= 1'b0;
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_phase_q) begin
                            ack_phase_q <= 1'b1;
                            sda_oe_q    <= ack_ok;
                            nxt_q       <= ST_RX;
                            nxt_kind_q  <= RX_DATA;
                            if (!ack_ok) begin
                                nxt_q <= ST_WAIT;
                            end else if (kind_q == RX_DEV) begin
                                if (shreg_q[0]) nxt_q <= ST_READ;
                                else            nxt_kind_q <= RX_ADDR;
                            end else if (kind_q == RX_ADDR) begin
                                addr_q <= shreg_q[AW-1:0];
                                blk4_q <= (WC_VARIANT == 0) && mode_i;
                            end else begin
                                wbuf_q[addr_q[PW-1:0]]  <= shreg_q;
                                wmask_q[addr_q[PW-1:0]] <= 1'b1;
                                wbase_q <= addr_q[AW-1:PW];
                                addr_q  <= addr_wr_next;
                            end
                        end else begin
                            ack_phase_q <= 1'b0;
                            state_q     <= nxt_q;
                            kind_q      <= nxt_kind_q;
                            bit_q       <= '0;
                            sda_oe_q    <= (nxt_q == ST_READ) ? ~rd_data[7] : 1'b0;
                        end
                    end
                    ST_READ: begin
                        if (scl_rise) begin
                            if (bit_q == 3'd7) state_q <= ST_MACK;
                            else               bit_q <= bit_q + 3'd1;
                        end else if (scl_fall && bit_q != 3'd0) begin
                            sda_oe_q <= ~rd_data[3'd7 - bit_q];
                        end
                    end
                    ST_MACK: begin
                        if (scl_fall) begin
                            sda_oe_q <= 1'b0;
                            addr_q   <= addr_q + AW'(1);
                        end else if (scl_rise) begin
                            state_q <= sda_s ? ST_WAIT : ST_RNEXT;
                        end
                    end
                    ST_RNEXT: if (scl_fall) begin
                        sda_oe_q <= ~rd_data[7];
                        bit_q    <= '0;
                        state_q  <= ST_READ;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = sda_oe_q;

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && ack_phase_q && kind_q == RX_DEV && prog_busy) |-> !sda_oe_q);

    // R8
    multi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && kind_q == RX_DATA && blk4_q) |=> $stable(addr_q[AW-1:MW]));

    // R7
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && kind_q == RX_DATA && !blk4_q) |=> $stable(addr_q[AW-1:PW]));

    // R11
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !sda_oe_q);

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_q && state_q == ST_IDLE));

endmodule

// File: tb/i2c_eeprom_slave_tb.sv
// Bench: two slaves on one bus (plain and write-control build), driven by a
// bit-level master, checked against byte models computed in the bench.
module i2c_eeprom_slave_tb;
    localparam int Q    = 5;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic mode0 = 1'b0;
    logic mode1 = 1'b0;
    logic oe0, oe1;
    logic sda_bus;
    int checks = 0;
    int errors = 0;
    bit glitch = 1'b0;
    logic [7:0] m0 [128];
    logic [7:0] m1 [128];

    assign sda_bus = sda_m & ~oe0 & ~oe1;

    always #10 clk = ~clk;

    i2c_eeprom_slave #(.PROG_CYCLES(PROG), .WC_VARIANT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(oe0), .chip_sel(3'b101), .mode_i(mode0));

    i2c_eeprom_slave #(.PROG_CYCLES(PROG), .WC_VARIANT(1)) u_wc (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(oe1), .chip_sel(3'b010), .mode_i(mode1));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(Q); sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(2*Q); sda_m = 1'b0; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(Q); sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(2*Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input bit b, output bit s);
        sda_m = b; tick(Q); scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(b[i], s);
            if (b[i] && !s) glitch = 1'b1;
        end
        put_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(output logic [7:0] d, input bit mack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s);
            d[i] = s;
        end
        put_bit(!mack, s);
    endtask

    function automatic logic [7:0] sel(input logic [2:0] dev, input bit rw);
        return {4'b1010, dev, rw};
    endfunction

    function automatic logic [7:0] model(input logic [2:0] dev, input int idx);
        return (dev == 3'b101) ? m0[idx & 127] : m1[idx & 127];
    endfunction

    // write n bytes of seed + 29*i; blk is the wrap size, ok the expected data ack
    task automatic do_write(input logic [2:0] dev, input logic [7:0] a, input int n,
                            input logic [7:0] seed, input int blk, input bit ok, input string req);
        bit ack;
        bus_start();
        send_byte(sel(dev, 1'b0), ack);
        chk(ack, req, ack, 1);
        send_byte(a, ack);
        chk(ack, req, ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            int idx;
            d = seed + 8'(29 * i);
            send_byte(d, ack);
            chk(ack == ok, req, ack, ok);
            if (ok) begin
                idx = (int'(a[6:0]) & ~(blk - 1)) | ((int'(a[6:0]) + i) & (blk - 1));
                if (dev == 3'b101) m0[idx] = d; else m1[idx] = d;
            end
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [2:0] dev, input logic [7:0] a, input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(sel(dev, 1'b0), ack);
        chk(ack, req, ack, 1);
        send_byte(a, ack);
        bus_start();
        send_byte(sel(dev, 1'b1), ack);
        chk(ack, req, ack, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(d, i != n - 1);
            chk(d == model(dev, int'(a[6:0]) + i), req, d, model(dev, int'(a[6:0]) + i));
        end
        bus_stop();
    endtask

    task automatic select_probe(input logic [2:0] dev, input bit exp, input string req);
        bit ack;
        bus_start();
        send_byte(sel(dev, 1'b0), ack);
        chk(ack == exp, req, ack, exp);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 128; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
        tick(8);
        rst_n = 1'b1;
        tick(4);
        // R1: outputs released after reset
        chk(!oe0 && !oe1, "R1", {oe0, oe1}, 0);

        // R1 R6: current-address read from reset state returns mem[0] = 0
        bus_start();
        send_byte(sel(3'b101, 1'b1), ack);
        chk(ack, "R2", ack, 1);
        read_byte(d, 1'b0);
        chk(d == 8'h00, "R1", d, 0);
        bus_stop();

        // R2: sweep all chip-enable values; only 101 and 010 answer
        for (int ce = 0; ce < 8; ce++) begin
            bus_start();
            send_byte(sel(3'(ce), 1'b0), ack);
            chk(ack == (ce == 5 || ce == 2), "R2", ack, (ce == 5 || ce == 2));
            bus_stop();
        end
        bus_start();
        send_byte(8'b1011_1010, ack);
        chk(!ack, "R2", ack, 0);
        bus_stop();

        // R10: address-only write leaves no programming cycle
        bus_start();
        send_byte(sel(3'b101, 1'b0), ack);
        send_byte(8'h40, ack);
        bus_stop();
        select_probe(3'b101, 1'b1, "R10");

        // R7: page write of 10 bytes at 0x13 wraps inside 0x10..0x17
        mode0 = 1'b0;
        do_write(3'b101, 8'h13, 10, 8'h11, 8, 1'b1, "R7");
        select_probe(3'b101, 1'b0, "R3");
        tick(PROG + 50);
        select_probe(3'b101, 1'b1, "R3");
        rand_read(3'b101, 8'h10, 8, "R7");

        // R8: multibyte write of 6 bytes at 0x7E wraps inside 0x7C..0x7F
        mode0 = 1'b1;
        do_write(3'b101, 8'h7E, 6, 8'hA5, 4, 1'b1, "R8");
        tick(PROG + 50);
        // R5 R4: read across the 127 -> 0 wrap, bit 7 of the address ignored
        rand_read(3'b101, 8'hFE, 4, "R5");

        // R6: counter is one past the last byte sent (0x7E + 4 -> 0x02)
        bus_start();
        send_byte(sel(3'b101, 1'b1), ack);
        read_byte(d, 1'b0);
        chk(d == m0[2], "R6", d, m0[2]);
        bus_stop();

        // R4: single byte writes spread over the array, both modes
        for (int k = 0; k < 8; k++) begin
            mode0 = k[0];
            do_write(3'b101, 8'(k * 16 + 5), 1, 8'(k * 37 + 1), k[0] ? 4 : 8, 1'b1, "R4");
            tick(PROG + 50);
        end
        // R5: one sequential read of the whole array
        rand_read(3'b101, 8'h00, 128, "R5");

        // R9: write-control build with the pin high refuses data
        mode1 = 1'b1;
        do_write(3'b010, 8'h30, 2, 8'h77, 8, 1'b0, "R9");
        select_probe(3'b010, 1'b1, "R9");
        rand_read(3'b010, 8'h30, 1, "R9");

        // R7: write-control build with the pin low takes an 8-byte page
        mode1 = 1'b0;
        do_write(3'b010, 8'h2C, 9, 8'h3C, 8, 1'b1, "R7");
        tick(PROG + 50);
        rand_read(3'b010, 8'h28, 8, "R7");

        // R11: after a master nack the slave leaves the bus alone
        bus_start();
        send_byte(sel(3'b101, 1'b1), ack);
        read_byte(d, 1'b0);
        begin
            int low = 0;
            bit s;
            for (int i = 0; i < 9; i++) begin
                put_bit(1'b1, s);
                if (!s) low++;
            end
            chk(low == 0, "R11", low, 0);
        end
        bus_stop();

        // R12: no acknowledge ever overlapped a 1 bit sent by the master
        chk(!glitch, "R12", glitch, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule